// File: doc/BRIEF.md
# Crypto Event Interrupt and DMA Request Router

This block gathers the four event conditions of a cipher engine: context needed on input, data needed on input, data ready on output, and result context ready on output. Software reads the raw levels of these conditions as a status word. It sets a mask of the same shape, and the block ORs the unmasked conditions onto a single interrupt line. The block also drives four DMA request lines, one per condition, and each line has its own enable bit in a configuration word. A DMA request stays high for as long as its condition and its enable are both high.

A fold option moves result-context traffic onto the data-output path. When the option is set, a result-context event raises the data-output DMA line and the interrupt, each through the data-output enable. The result-context DMA line stays low, and both result-context enable bits are ignored. The result-context condition is raised by the engine only when a job ends while context saving is requested. At that point an authentication tag or result IV is waiting to be collected.

Software reaches four word registers through a simple port. Writes take effect at the clock edge, and reads are combinational. The interrupt and request outputs follow the event inputs with no register stage.

Top module: `evr_event_router`

## Requirements
- R1: Address 0 reads the event levels: bit 0 context-in, bit 1 data-in, bit 2 data-out, bit 3 context-out, all other bits 0. Writes to address 0 change nothing.
- R2: Address 1 holds the interrupt mask in bits 3:0, in the same layout as address 0. It reads back what was written, with the upper bits reading 0, and it is 0 after reset.
- R3: With folding off, `irq` is high exactly when some event bit and its mask bit are both 1, in the same cycle as the inputs.
- R4: Address 2 holds the configuration. Bit 5 enables data-in DMA, bit 6 data-out DMA, bit 7 context-in DMA, bit 8 context-out DMA, and bit 9 turns folding on. All other bits read 0, and the whole word is 0 after reset.
- R5: With folding off, each `dma_req[k]` (indexed in the address-0 layout) equals event k AND its DMA enable, combinationally, and drops as soon as the event drops.
- R6: With folding on, `dma_req[2]` is (data-out OR context-out) AND the data-out DMA enable. `dma_req[3]` is 0 and the context-out DMA enable has no effect.
- R7: With folding on, the context-out event reaches `irq` through mask bit 2, and mask bit 3 has no effect.
- R8: Address 3 bit 0 reads 0 while reset is held. It reads 1 from the first clock edge after reset is released. All other bits read 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_lvl | input | 4 | Event condition levels, in the address-0 layout |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt output |
| dma_req | output | 4 | DMA request lines, in the address-0 layout |

## Verification
The bench goes after the fold option. With folding on and only the context-out mask or context-out DMA enable set, a design that ignored the fold would raise `irq` or `dma_req[3]`. A design that failed to fold would leave `dma_req[2]` low when only context-out is active. The bench mixes in random writes to the status word, and a writable status word would then return stale data. It also samples the reset-done bit in the cycle right after release, and a design that set it late or during reset would read wrong there.

// File: rtl/evr_pkg.sv
package evr_pkg;
  // event positions shared by status, mask and DMA line vectors
  localparam int EV_N      = 4;
  localparam int EV_CIN    = 0;
  localparam int EV_DIN    = 1;
  localparam int EV_DOUT   = 2;
  localparam int EV_COUT   = 3;
  // configuration word bit positions
  localparam int CFG_DIN   = 5;
  localparam int CFG_DOUT  = 6;
  localparam int CFG_CIN   = 7;
  localparam int CFG_COUT  = 8;
  localparam int CFG_FOLD  = 9;
  // word addresses
  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_MASK = 2'd1;
  localparam logic [1:0] ADR_CFG  = 2'd2;
  localparam logic [1:0] ADR_SYS  = 2'd3;

  // fold context-out onto data-out when requested
  function automatic logic [EV_N-1:0] fold_src(input logic [EV_N-1:0] ev, input logic fold);
    logic [EV_N-1:0] r;
    r = ev;
    if (fold) begin
      r[EV_DOUT] = ev[EV_DOUT] | ev[EV_COUT];
      r[EV_COUT] = 1'b0;
    end
    return r;
  endfunction

  // drop the context-out enable when folding
  function automatic logic [EV_N-1:0] fold_en(input logic [EV_N-1:0] en, input logic fold);
    logic [EV_N-1:0] r;
    r = en;
    if (fold) r[EV_COUT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/evr_regs.sv
module evr_regs
  import evr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [EV_N-1:0] ev,
  output logic [EV_N-1:0] mask,
  output logic [EV_N-1:0] dma_en,
  output logic          fold,
  output logic [DW-1:0] rdata
);
  localparam int CFG_W = CFG_FOLD - CFG_DIN + 1;

  logic [EV_N-1:0]  mask_q;
  logic [CFG_W-1:0] cfg_q;
  logic             rst_done_q;
  logic             wr_mask, wr_cfg;

  assign wr_mask = we && (addr == ADR_MASK);
  assign wr_cfg  = we && (addr == ADR_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      cfg_q      <= '0;
      rst_done_q <= 1'b0;
    end else begin
      rst_done_q <= 1'b1;
      if (wr_mask) mask_q <= wdata[EV_N-1:0];
      if (wr_cfg)  cfg_q  <= wdata[CFG_FOLD:CFG_DIN];
    end
  end

  assign mask = mask_q;
  assign fold = cfg_q[CFG_FOLD-CFG_DIN];
  assign dma_en[EV_CIN]  = cfg_q[CFG_CIN-CFG_DIN];
  assign dma_en[EV_DIN]  = cfg_q[CFG_DIN-CFG_DIN];
  assign dma_en[EV_DOUT] = cfg_q[CFG_DOUT-CFG_DIN];
  assign dma_en[EV_COUT] = cfg_q[CFG_COUT-CFG_DIN];

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_STAT: rdata[EV_N-1:0] = ev;
      ADR_MASK: rdata[EV_N-1:0] = mask_q;
      ADR_CFG:  rdata[CFG_FOLD:CFG_DIN] = cfg_q;
      default:  rdata[0] = rst_done_q;
    endcase
  end

  AST_RSTDONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rst_done_q); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q)); // R4
endmodule

// File: rtl/evr_route.sv
module evr_route
  import evr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev,
  input  logic [EV_N-1:0] mask,
  input  logic [EV_N-1:0] dma_en,
  input  logic            fold,
  output logic            irq,
  output logic [EV_N-1:0] dma_req
);
  logic [EV_N-1:0] src_eff;
  logic [EV_N-1:0] mask_eff;
  logic [EV_N-1:0] den_eff;

  assign src_eff  = fold_src(ev, fold);
  assign mask_eff = fold_en(mask, fold);
  assign den_eff  = fold_en(dma_en, fold);

  assign irq = |(src_eff & mask_eff);

  for (genvar k = 0; k < EV_N; k++) begin : g_line
    assign dma_req[k] = src_eff[k] & den_eff[k];
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R3
  AST_DMA_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fold && dma_req[EV_DIN]) |-> ev[EV_DIN]); // R5
  AST_FOLD_COUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fold |-> !dma_req[EV_COUT]); // R6
  AST_FOLD_DOUT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && dma_req[EV_DOUT]) |-> (ev[EV_DOUT] || ev[EV_COUT])); // R6
  AST_FOLD_MASK3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && mask[EV_DOUT] == 1'b0 && (ev & mask & 4'b0011) == '0) |-> !irq); // R7
endmodule

// File: rtl/evr_event_router.sv
module evr_event_router
  import evr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ev_lvl,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic [3:0]    dma_req
);
  logic [EV_N-1:0] mask_w;
  logic [EV_N-1:0] dma_en_w;
  logic            fold_w;

  evr_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ev     (ev_lvl),
    .mask   (mask_w),
    .dma_en (dma_en_w),
    .fold   (fold_w),
    .rdata  (reg_rdata)
  );

  evr_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_lvl),
    .mask    (mask_w),
    .dma_en  (dma_en_w),
    .fold    (fold_w),
    .irq     (irq),
    .dma_req (dma_req)
  );
endmodule

// File: tb/evr_event_router_test.sv
`timescale 1ns/100ps
module evr_event_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ev_lvl = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [3:0]  dma_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0]  sh_mask = '0;
  logic [31:0] sh_cfg = '0;

  always #2 clk = ~clk;

  evr_event_router uut (
    .clk(clk), .rst_n(rst_n), .ev_lvl(ev_lvl), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .dma_req(dma_req)
  );

  // reference: fold flag is config bit 9, DMA enables at bits 5..8 = din,dout,cin,cout
  function automatic logic [3:0] ref_den(input logic [31:0] c);
    return {c[8], c[6], c[5], c[7]};
  endfunction

  function automatic logic ref_irq(input logic [3:0] e, input logic [3:0] m, input logic [31:0] c);
    if (!c[9]) return |(e & m);
    return (e[0] & m[0]) | (e[1] & m[1]) | ((e[2] | e[3]) & m[2]);
  endfunction

  function automatic logic [3:0] ref_dma(input logic [3:0] e, input logic [31:0] c);
    logic [3:0] d;
    d = ref_den(c);
    if (!c[9]) return e & d;
    return {1'b0, (e[2] | e[3]) & d[2], e[1] & d[1], e[0] & d[0]};
  endfunction

  function automatic logic [31:0] ref_rd(input logic [1:0] a, input logic [3:0] e);
    case (a)
      2'd0: return {28'd0, e};
      2'd1: return {28'd0, sh_mask};
      2'd2: return sh_cfg;
      default: return 32'd1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #0.5 reg_we = 1'b0;
    if (a == 2'd1) sh_mask = d[3:0];
    if (a == 2'd2) sh_cfg = d & 32'h0000_03E0;
  endtask

  task automatic check_all(input logic [1:0] a, input string tag);
    reg_addr = a;
    #0.5;
    chk(irq === ref_irq(ev_lvl, sh_mask, sh_cfg), {tag, " irq"}, {31'd0, irq}, {31'd0, ref_irq(ev_lvl, sh_mask, sh_cfg)});
    chk(dma_req === ref_dma(ev_lvl, sh_cfg), {tag, " dma"}, {28'd0, dma_req}, {28'd0, ref_dma(ev_lvl, sh_cfg)});
    chk(reg_rdata === ref_rd(a, ev_lvl), {tag, " rdata"}, reg_rdata, ref_rd(a, ev_lvl));
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    // reset state: R8 reads 0 during reset, R2/R4 zero
    repeat (3) @(posedge clk);
    #0.5 reg_addr = 2'd3; #0.5;
    chk(reg_rdata === 32'd0, "R8 during reset", reg_rdata, 32'd0);
    reg_addr = 2'd1; #0.5;
    chk(reg_rdata === 32'd0, "R2 mask reset", reg_rdata, 32'd0);
    reg_addr = 2'd2; #0.5;
    chk(reg_rdata === 32'd0, "R4 cfg reset", reg_rdata, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    reg_addr = 2'd3; #0.5;
    chk(reg_rdata === 32'd0, "R8 before first edge", reg_rdata, 32'd0);
    @(posedge clk); #0.5;
    chk(reg_rdata === 32'd1, "R8 after first edge", reg_rdata, 32'd1);

    // R1: status is read-only
    ev_lvl = 4'b1010;
    wr(2'd0, 32'hFFFF_FFFF);
    check_all(2'd0, "R1 status ignores write");

    // R3/R5 directed, no fold
    wr(2'd1, 32'hFFFF_FFF4);
    wr(2'd2, 32'hFFFF_FD60);
    ev_lvl = 4'b0100; check_all(2'd1, "R3 R5 dout only");
    ev_lvl = 4'b0000; check_all(2'd2, "R5 drops with event");
    ev_lvl = 4'b1011; check_all(2'd2, "R3 R4 unmasked events");

    // R6/R7 directed with fold, only context-out enables set
    wr(2'd2, 32'h0000_0300);
    wr(2'd1, 32'h0000_0008);
    ev_lvl = 4'b1000; check_all(2'd2, "R6 R7 cout enables ignored");
    chk(irq === 1'b0, "R7 mask3 ignored", {31'd0, irq}, 32'd0);
    chk(dma_req === 4'b0000, "R6 cout line low", {28'd0, dma_req}, 32'd0);
    // fold with data-out enables
    wr(2'd2, 32'h0000_0240);
    wr(2'd1, 32'h0000_0004);
    check_all(2'd1, "R6 R7 cout folded");
    chk(dma_req === 4'b0100, "R6 folded onto dout", {28'd0, dma_req}, 32'h4);
    chk(irq === 1'b1, "R7 folded irq", {31'd0, irq}, 32'd1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom_range(0, 3));
      d = $urandom();
      @(negedge clk);
      ev_lvl = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) wr(a, d);
      check_all(2'($urandom_range(0, 3)), "R1 R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule